// File: doc/BRIEF.md
# Dual external interrupt line controller

This block gives an 8-bit microcontroller core two extra active-low external interrupt inputs. Each input has four control bits: a trigger-type select, a pending flag, an enable and a priority marker. All eight bits sit in one special function register that is also bit-addressable. The core reads and writes the whole byte through a byte port. A single-bit port lets the core set or clear any one of the eight bits.

Each pin passes through a two-stage synchronizer. After that, the block detects either a falling edge or a low level, as the line's type bit selects. It raises a request toward the core's interrupt arbiter whenever the pending flag and the enable are both set, and it presents the line's priority bit alongside the request. In edge mode the core's service acknowledge clears the pending flag, and software may also write the flag to raise an interrupt by program. In level mode the flag simply tracks the synchronized pin.

Top module: `extirq_ctl`

## Requirements
- R1: After reset the register reads 0x00, and `irq_req` and `irq_prio` are both 0.
- R2: A byte write with `sfr_addr` = 0xC0 loads the register, and the new value reads back one cycle later. Reads of address 0xC0 return the register. Any other address reads 0x00. A byte write to any other address changes nothing. The flag bits are only loaded by a byte write when their line is in edge mode.
- R3: Register layout, per line n (n = 0 or 1), at bit 4n+k: k=0 trigger type (1 = falling edge, 0 = low level), k=1 pending flag, k=2 enable, k=3 priority (1 = high). A single-bit write with `bit_addr` = 0xC0+i (i = 0..7) loads bit i with `bit_val`. Bit addresses outside 0xC0..0xC7 are ignored. Example: 0xC2 is the enable of line 0.
- R4: In edge mode, a high-to-low change on `xint_n[n]` sets the flag on the third rising clock edge after the change. A pin that stays low does not set the flag again once it has been cleared.
- R5: In level mode, the flag equals the inverted pin, delayed by three clock edges. Acknowledge does not clear it, and software writes to it have no effect.
- R6: In edge mode, `irq_ack[n]` clears the flag on the next clock edge.
- R7: In edge mode, when a detected falling edge and `irq_ack[n]` fall on the same clock edge, the flag ends up set.
- R8: In edge mode, a software write of the flag (byte or single-bit) sets or clears it, so the program can raise a request.
- R9: `irq_req[n]` is 1 exactly when both the flag and the enable of line n are 1. `irq_prio[n]` equals the priority bit of line n.
- R10: A low-to-high change on `xint_n[n]` never sets the flag in edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Byte register address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Register value when addressed, else 0 |
| bit_addr | input | 8 | Single-bit address |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_val | input | 1 | Value written to the addressed bit |
| xint_n | input | 2 | Active-low interrupt pins |
| irq_ack | input | 2 | Service acknowledge per line |
| irq_req | output | 2 | Interrupt request per line |
| irq_prio | output | 2 | Priority marker per line |

## Verification
The race that matters is between a newly detected falling edge and the core's acknowledge on the same line, since both act on the pending flag in one clock edge. The bench first sets the flag by software. It then drops the pin and asserts the acknowledge in exactly the cycle in which the synchronized fall reaches the flag register. It judges the outcome by reading back the flag, which must remain set, and by a behavioural model compared on every clock. A plain acknowledge issued a little later must then clear the flag, which shows that the flag survived because of the edge and not because the acknowledge was ignored.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

   localparam int FIELDS_PER_LINE = 4;
   localparam int F_TYPE = 0;
   localparam int F_FLAG = 1;
   localparam int F_EN   = 2;
   localparam int F_PRIO = 3;

   // Packed per-line control fields; LSB is the trigger type.
   typedef struct packed {
      logic prio;
      logic en;
      logic flag;
      logic trig_edge;
   } line_ctl_t;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic lvl_low,
   output logic fall
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b1;
            else        chain_q <= pin_n;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pin_n};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign lvl_low = ~chain_q[STAGES-1];
   assign fall    = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/extirq_decode.sv
module extirq_decode #(
   parameter int         REG_W     = 8,
   parameter logic [7:0] BYTE_ADDR = 8'hC0,
   parameter logic [7:0] BIT_BASE  = 8'hC0
) (
   input  logic [7:0]       sfr_addr,
   input  logic             sfr_wr,
   input  logic [7:0]       sfr_wdata,
   input  logic [7:0]       bit_addr,
   input  logic             bit_wr,
   input  logic             bit_val,
   input  logic [REG_W-1:0] cur,
   output logic [REG_W-1:0] wr_mask,
   output logic [REG_W-1:0] wr_data,
   output logic             wr_any
);

   localparam int IDX_W = (REG_W > 1) ? $clog2(REG_W) : 1;

   logic [8:0]       bit_diff;
   logic             bit_hit;
   logic [IDX_W-1:0] bit_idx;

   assign bit_diff = {1'b0, bit_addr} - {1'b0, BIT_BASE};
   assign bit_hit  = (bit_diff < 9'(REG_W));
   assign bit_idx  = bit_diff[IDX_W-1:0];

   // Byte write first, then a single-bit write overrides its bit.
   always_comb begin
      wr_mask = '0;
      wr_data = cur;
      if (sfr_wr && (sfr_addr == BYTE_ADDR)) begin
         wr_mask = '1;
         wr_data = sfr_wdata[REG_W-1:0];
      end
      if (bit_wr && bit_hit) begin
         wr_mask[bit_idx] = 1'b1;
         wr_data[bit_idx] = bit_val;
      end
   end

   assign wr_any = |wr_mask;

endmodule

// File: rtl/extirq_line.sv
module extirq_line
   import extirq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  line_ctl_t wr_mask,
   input  line_ctl_t wr_data,
   input  logic      fall,
   input  logic      lvl_low,
   input  logic      ack,
   output line_ctl_t ctl,
   output logic      req
);

   line_ctl_t q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         if (wr_mask.trig_edge) q.trig_edge <= wr_data.trig_edge;
         if (wr_mask.en)        q.en        <= wr_data.en;
         if (wr_mask.prio)      q.prio      <= wr_data.prio;
         if (q.trig_edge) begin
            // A new edge outranks software and acknowledge.
            if (fall)              q.flag <= 1'b1;
            else if (wr_mask.flag) q.flag <= wr_data.flag;
            else if (ack)          q.flag <= 1'b0;
         end else begin
            q.flag <= lvl_low;
         end
      end
   end

   assign ctl = q;
   assign req = q.flag & q.en;

endmodule

// File: rtl/extirq_ctl.sv
module extirq_ctl
   import extirq_pkg::*;
#(
   parameter logic [7:0] CTRL_ADDR   = 8'hC0,
   parameter int         NUM_LINES   = 2,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [7:0]           sfr_addr,
   input  logic                 sfr_wr,
   input  logic [7:0]           sfr_wdata,
   output logic [7:0]           sfr_rdata,
   input  logic [7:0]           bit_addr,
   input  logic                 bit_wr,
   input  logic                 bit_val,
   input  logic [NUM_LINES-1:0] xint_n,
   input  logic [NUM_LINES-1:0] irq_ack,
   output logic [NUM_LINES-1:0] irq_req,
   output logic [NUM_LINES-1:0] irq_prio
);

   localparam int REG_W = NUM_LINES * FIELDS_PER_LINE;

   initial begin
      if (REG_W != 8)
         $fatal(1, "extirq_ctl: line fields must fill one byte register");
      if (SYNC_STAGES < 2)
         $fatal(1, "extirq_ctl: at least two synchronizer stages needed");
      if ($bits(line_ctl_t) != FIELDS_PER_LINE)
         $fatal(1, "extirq_ctl: field struct width mismatch");
   end

   logic [REG_W-1:0]     ctl_q;
   logic [REG_W-1:0]     wr_mask;
   logic [REG_W-1:0]     wr_data;
   logic                 wr_any;
   logic [NUM_LINES-1:0] fall_det;
   logic [NUM_LINES-1:0] sync_low;

   extirq_decode #(
      .REG_W     (REG_W),
      .BYTE_ADDR (CTRL_ADDR),
      .BIT_BASE  (CTRL_ADDR)
   ) u_dec (
      .sfr_addr  (sfr_addr),
      .sfr_wr    (sfr_wr),
      .sfr_wdata (sfr_wdata),
      .bit_addr  (bit_addr),
      .bit_wr    (bit_wr),
      .bit_val   (bit_val),
      .cur       (ctl_q),
      .wr_mask   (wr_mask),
      .wr_data   (wr_data),
      .wr_any    (wr_any)
   );

   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
         line_ctl_t line_q;

         extirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_n   (xint_n[n]),
            .lvl_low (sync_low[n]),
            .fall    (fall_det[n])
         );

         extirq_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_mask (line_ctl_t'(wr_mask[n*FIELDS_PER_LINE +: FIELDS_PER_LINE])),
            .wr_data (line_ctl_t'(wr_data[n*FIELDS_PER_LINE +: FIELDS_PER_LINE])),
            .fall    (fall_det[n]),
            .lvl_low (sync_low[n]),
            .ack     (irq_ack[n]),
            .ctl     (line_q),
            .req     (irq_req[n])
         );

         assign ctl_q[n*FIELDS_PER_LINE +: FIELDS_PER_LINE] = line_q;
         assign irq_prio[n] = line_q.prio;
      end
   endgenerate

   assign sfr_rdata = (sfr_addr == CTRL_ADDR) ? ctl_q : 8'h00;

endmodule

// File: rtl/extirq_ctl_chk.sv
module extirq_ctl_chk #(
   parameter int NUM_LINES = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [4*NUM_LINES-1:0] ctl,
   input logic [NUM_LINES-1:0]   fall,
   input logic [NUM_LINES-1:0]   lvl_low,
   input logic                   wr_any,
   input logic [NUM_LINES-1:0]   irq_ack,
   input logic [NUM_LINES-1:0]   irq_req
);

   generate
      for (genvar n = 0; n < NUM_LINES; n++) begin : g_chk
         // R9
         req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[n] |-> ctl[4*n+2]);
         // R9
         req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_req[n] |-> ctl[4*n+1]);
         // R7
         edge_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[4*n] && fall[n]) |=> ctl[4*n+1]);
         // R6
         ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl[4*n] && irq_ack[n] && !fall[n] && !wr_any) |=> !ctl[4*n+1]);
         // R5
         level_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctl[4*n] && !wr_any) |=> (ctl[4*n+1] == $past(lvl_low[n])));
      end
   endgenerate

endmodule

bind extirq_ctl extirq_ctl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ctl     (ctl_q),
   .fall    (fall_det),
   .lvl_low (sync_low),
   .wr_any  (wr_any),
   .irq_ack (irq_ack),
   .irq_req (irq_req)
);

// File: tb/extirq_ctl_tb.sv
module extirq_ctl_tb_top;

   localparam int CLK_P = 10;
   localparam logic [7:0] RA = 8'hC0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = RA;
   logic       sfr_wr = 1'b0;
   logic [7:0] sfr_wdata = 8'h00;
   logic [7:0] sfr_rdata;
   logic [7:0] bit_addr = 8'h00;
   logic       bit_wr = 1'b0;
   logic       bit_val = 1'b0;
   logic [1:0] xint_n = 2'b11;
   logic [1:0] irq_ack = 2'b00;
   logic [1:0] irq_req;
   logic [1:0] irq_prio;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   extirq_ctl dut_i (
      .clk(clk), .rst_n(rst_n),
      .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .bit_addr(bit_addr), .bit_wr(bit_wr), .bit_val(bit_val),
      .xint_n(xint_n), .irq_ack(irq_ack), .irq_req(irq_req), .irq_prio(irq_prio)
   );

   // Behavioural reference: register byte plus three-deep pin history.
   logic [7:0] m_reg = 8'h00;
   logic [1:0] m_h1 = 2'b11, m_h2 = 2'b11, m_h3 = 2'b11;

   always @(posedge clk) begin
      logic [7:0] mk, md, nx;
      if (!rst_n) begin
         m_reg = 8'h00; m_h1 = 2'b11; m_h2 = 2'b11; m_h3 = 2'b11;
      end else begin
         mk = 8'h00; md = m_reg;
         if (sfr_wr && sfr_addr == RA) begin mk = 8'hFF; md = sfr_wdata; end
         if (bit_wr && bit_addr >= 8'hC0 && bit_addr <= 8'hC7) begin
            int i;
            i = int'(bit_addr) - 192;
            mk[i] = 1'b1; md[i] = bit_val;
         end
         nx = m_reg;
         for (int n = 0; n < 2; n++) begin
            int b;
            b = 4*n;
            if (mk[b])   nx[b]   = md[b];
            if (mk[b+2]) nx[b+2] = md[b+2];
            if (mk[b+3]) nx[b+3] = md[b+3];
            if (m_reg[b]) begin
               if (m_h3[n] && !m_h2[n]) nx[b+1] = 1'b1;
               else if (mk[b+1])        nx[b+1] = md[b+1];
               else if (irq_ack[n])     nx[b+1] = 1'b0;
            end else begin
               nx[b+1] = !m_h2[n];
            end
         end
         m_reg = nx;
         m_h3 = m_h2; m_h2 = m_h1; m_h1 = xint_n;
      end
   end

   // Compare a quarter period after each rising edge.
   always @(posedge clk) begin
      logic [7:0] exp_rd;
      logic [1:0] exp_req, exp_pr;
      #(CLK_P/4);
      if (rst_n && !done) begin
         exp_rd  = (sfr_addr == RA) ? m_reg : 8'h00;
         exp_req = {m_reg[5] & m_reg[6], m_reg[1] & m_reg[2]};
         exp_pr  = {m_reg[7], m_reg[3]};
         tests++;
         if (sfr_rdata !== exp_rd || irq_req !== exp_req || irq_prio !== exp_pr) begin
            fails++;
            $display("FAIL R2/R9 model: rd=%h req=%b prio=%b expected rd=%h req=%b prio=%b",
                     sfr_rdata, irq_req, irq_prio, exp_rd, exp_req, exp_pr);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      tick(1);
      sfr_wr = 1'b0; sfr_addr = RA;
   endtask

   task automatic wr_bit(input logic [7:0] a, input logic v);
      bit_addr = a; bit_val = v; bit_wr = 1'b1;
      tick(1);
      bit_wr = 1'b0;
   endtask

   task automatic pulse_ack(input logic [1:0] a);
      irq_ack = a;
      tick(1);
      irq_ack = 2'b00;
   endtask

   initial begin
      tick(3);
      // R1
      chk("R1 reset read", sfr_rdata, 8'h00);
      chk("R1 reset req", irq_req, 0);
      chk("R1 reset prio", irq_prio, 0);
      rst_n = 1'b1;
      tick(2);

      // R2: other addresses
      wr_byte(8'h90, 8'hFF);
      chk("R2 foreign write ignored", sfr_rdata, 8'h00);
      sfr_addr = 8'h90; tick(1);
      chk("R2 foreign read zero", sfr_rdata, 8'h00);
      sfr_addr = RA;
      wr_byte(RA, 8'hDD);
      chk("R2 byte readback", sfr_rdata, 8'hDD);
      chk("R9 prio out", irq_prio, 2'b11);
      wr_byte(RA, 8'h00);

      // R3: single-bit writes
      wr_bit(8'hC2, 1'b1);
      chk("R3 bit C2 sets enable0", sfr_rdata, 8'h04);
      wr_bit(8'hC8, 1'b1);
      chk("R3 bit C8 ignored", sfr_rdata, 8'h04);
      wr_bit(8'hBF, 1'b1);
      chk("R3 bit BF ignored", sfr_rdata, 8'h04);
      wr_bit(8'hC7, 1'b1);
      chk("R3 bit C7 sets prio1", sfr_rdata, 8'h84);
      wr_bit(8'hC2, 1'b0);
      wr_bit(8'hC7, 1'b0);
      chk("R3 bits cleared", sfr_rdata, 8'h00);

      // R4: edge mode line 0
      wr_byte(RA, 8'h05);
      xint_n[0] = 1'b0;
      tick(2);
      chk("R4 not yet after two edges", sfr_rdata, 8'h05);
      tick(1);
      chk("R4 set on third edge", sfr_rdata, 8'h07);
      chk("R9 req with flag and enable", irq_req, 2'b01);
      // R6
      pulse_ack(2'b01);
      chk("R6 ack clears", sfr_rdata, 8'h05);
      tick(5);
      chk("R4 steady low no retrigger", sfr_rdata, 8'h05);
      // R10
      xint_n[0] = 1'b1;
      tick(4);
      chk("R10 rising edge ignored", sfr_rdata, 8'h05);

      // R8: software raise and clear
      wr_bit(8'hC1, 1'b1);
      chk("R8 software set", sfr_rdata, 8'h07);
      chk("R8 software req", irq_req, 2'b01);
      wr_bit(8'hC1, 1'b0);
      chk("R8 software clear", sfr_rdata, 8'h05);

      // R7: edge and ack on the same clock edge
      wr_bit(8'hC1, 1'b1);
      xint_n[0] = 1'b0;
      tick(2);
      irq_ack = 2'b01;
      tick(1);
      irq_ack = 2'b00;
      chk("R7 edge wins over ack", sfr_rdata, 8'h07);
      pulse_ack(2'b01);
      chk("R6 later ack clears", sfr_rdata, 8'h05);
      xint_n[0] = 1'b1;
      tick(4);

      // R5: level mode line 1
      wr_byte(RA, 8'hC5);
      xint_n[1] = 1'b0;
      tick(2);
      chk("R5 level not yet", sfr_rdata, 8'hC5);
      tick(1);
      chk("R5 level follows low", sfr_rdata, 8'hE5);
      chk("R9 req line1", irq_req, 2'b10);
      chk("R9 prio line1", irq_prio, 2'b10);
      pulse_ack(2'b10);
      chk("R5 ack ignored in level", sfr_rdata, 8'hE5);
      wr_bit(8'hC5, 1'b0);
      chk("R5 soft clear ignored", sfr_rdata, 8'hE5);
      xint_n[1] = 1'b1;
      tick(3);
      chk("R5 level follows high", sfr_rdata, 8'hC5);

      // R9: flag set without enable gives no request
      wr_byte(RA, 8'h03);
      chk("R9 flag without enable read", sfr_rdata, 8'h03);
      chk("R9 flag without enable req", irq_req, 2'b00);
      wr_bit(8'hC2, 1'b1);
      chk("R9 enable raises req", irq_req, 2'b01);

      tick(3);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(CLK_P*20000);
      if (!done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule